// File: doc/BRIEF.md
# 64-bit Barrel Shifter with Word-Mode Sign Extension

This is a combinational shift unit for the execute stage of a 64-bit processor. It performs logical left, logical right and arithmetic right shifts on 32-bit words and on 64-bit doublewords. The shift amount comes from one of three places: a 5-bit immediate field, the low bits of a 64-bit register value, or the immediate plus 32. The immediate plus 32 form exists for the doubleword operations only. A 4-bit encoded operation code chooses the form. The decoder and the register file sit outside this block, and the result appears in the same cycle.

Internally there is a single six-stage log-depth right shifter. For left shifts the operand is bit-reversed on the way in and on the way out. A word-mode result is always the low 32 bits of the shifted value, sign-extended from bit 31.

Top module: `shift64_unit`

## Requirements
- R1: Op code 0 (word shift left, immediate amount) gives the low 32 bits of the operand shifted left by the immediate amount, sign-extended from bit 31 to 64 bits.
- R2: Op code 1 (word logical right, immediate amount) shifts only the low 32 bits of the operand right with zero fill, then sign-extends the 32-bit result. Operand bits 63..32 have no effect.
- R3: Op code 2 (word arithmetic right, immediate amount) shifts the full 64-bit operand arithmetically right, then sign-extends its low 32 bits. Operand bits above bit 31 can therefore reach the result.
- R4: Op codes 3, 4 and 5 are the register-amount forms of codes 0, 1 and 2. They use only bits 4..0 of the amount register. Op codes 9, 10 and 11 are the register-amount forms of codes 6, 7 and 8, and use only bits 5..0. Higher register bits have no effect.
- R5: Op code 6 (doubleword shift left) and op code 7 (doubleword logical right) shift all 64 bits by the immediate amount and fill with zeros.
- R6: Op code 8 (doubleword arithmetic right) shifts all 64 bits by the immediate amount and fills with copies of operand bit 63.
- R7: Op codes 12, 13 and 14 behave like codes 6, 7 and 8, but the amount is the immediate plus 32, which covers 32 to 63.
- R8: An amount of zero returns the operand unchanged in doubleword modes. In word modes it returns the low 32 bits sign-extended.
- R9: Op code 15 is unused and gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 64 | Operand to be shifted |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 64 | Register value that supplies the variable amount |
| op_i | input | 4 | Encoded operation (codes 0 to 15) |
| res_o | output | 64 | Shift result |

## Verification
The bench targets the word arithmetic right shift with ones or zeros placed above bit 31. A design that shifts only the low word would lose those bits from the result. It also drives register amounts with junk in bit 5 and above. A word shift that kept bit 5 would produce zero or a wrong result, and a doubleword shift that dropped bit 5 would shift by less than intended. The plus-32 forms are tested at immediates 0 and 31; a design that forgets the offset returns the operand or a short shift. Word results with bit 31 set are checked for ones in the upper half, which catches a design that zero-extends.

// File: rtl/shift64_unit.sv
module shift64_unit #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] opnd_i,
  input  logic [4:0]    imm_amt_i,
  input  logic [DW-1:0] reg_amt_i,
  input  logic [3:0]    op_i,
  output logic [DW-1:0] res_o
);
  localparam int HW = DW / 2;
  localparam int SW = $clog2(DW);

  logic          word_m, left_m, arith_m, zero_m;
  logic [SW-1:0] amt;
  logic [DW-1:0] src, rev_in, shifted, rev_out;
  logic [DW-1:0] stg [0:SW];
  logic          fill;

  always_comb begin
    word_m  = op_i < 4'd6;
    zero_m  = op_i == 4'd15;
    left_m  = (op_i % 4'd3) == 4'd0;
    arith_m = (op_i % 4'd3) == 4'd2;
    unique case (op_i)
      4'd0, 4'd1, 4'd2, 4'd6, 4'd7, 4'd8: amt = {1'b0, imm_amt_i};
      4'd3, 4'd4, 4'd5:                   amt = {1'b0, reg_amt_i[4:0]};
      4'd9, 4'd10, 4'd11:                 amt = reg_amt_i[SW-1:0];
      4'd12, 4'd13, 4'd14:                amt = {1'b1, imm_amt_i};
      default:                            amt = '0;
    endcase
  end

  assign src  = (word_m && !arith_m) ? {{HW{1'b0}}, opnd_i[HW-1:0]} : opnd_i;
  assign fill = arith_m & src[DW-1];

  generate
    for (genvar i = 0; i < DW; i++) begin : g_rev
      assign rev_in[i]  = src[DW-1-i];
      assign rev_out[i] = stg[SW][DW-1-i];
    end
  endgenerate

  assign stg[0] = left_m ? rev_in : src;

  generate
    for (genvar k = 0; k < SW; k++) begin : g_stage
      localparam int D = 1 << k;
      assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][DW-1:D]} : stg[k];
    end
  endgenerate

  assign shifted = left_m ? rev_out : stg[SW];
  assign res_o   = zero_m ? '0 :
                   word_m ? {{HW{shifted[HW-1]}}, shifted[HW-1:0]} : shifted;
endmodule

// File: rtl/shift64_unit_chk.sv
module shift64_unit_chk (
  input logic [63:0] opnd_i,
  input logic [4:0]  imm_amt_i,
  input logic [63:0] reg_amt_i,
  input logic [3:0]  op_i,
  input logic [63:0] res_o
);
  always @* begin
    if (!$isunknown({opnd_i, imm_amt_i, reg_amt_i, op_i, res_o})) begin
      if (op_i < 4'd6)
        p_word_sext_r1: assert (res_o[63:32] == {32{res_o[31]}});
      if (op_i == 4'd1 && imm_amt_i != 5'd0)
        p_wlr_top_clear_r2: assert (res_o[31] == 1'b0);
      if (op_i == 4'd7 && imm_amt_i != 5'd0)
        p_dlr_zero_fill_r5: assert (res_o[63] == 1'b0);
      if (op_i == 4'd8)
        p_dar_sign_r6: assert (res_o[63] == opnd_i[63]);
      if (op_i == 4'd12)
        p_plus32_left_r7: assert (res_o[31:0] == 32'd0);
      if (op_i == 4'd13)
        p_plus32_right_r7: assert (res_o[63:32] == 32'd0);
      if (op_i >= 4'd6 && op_i <= 4'd8 && imm_amt_i == 5'd0)
        p_zero_pass_r8: assert (res_o == opnd_i);
      if (op_i == 4'd15)
        p_unused_zero_r9: assert (res_o == 64'd0);
    end
  end
endmodule

bind shift64_unit shift64_unit_chk chk (
  .opnd_i(opnd_i), .imm_amt_i(imm_amt_i), .reg_amt_i(reg_amt_i),
  .op_i(op_i), .res_o(res_o)
);

// File: tb/shift64_unit_test.sv
module shift64_unit_test;
  logic        clk = 1'b0;
  logic [63:0] opnd, ramt, res;
  logic [4:0]  imm;
  logic [3:0]  op;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  shift64_unit uut (.opnd_i(opnd), .imm_amt_i(imm), .reg_amt_i(ramt), .op_i(op), .res_o(res));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [63:0] sx32(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] x,
                                        input logic [4:0] im, input logic [63:0] r);
    logic signed [63:0] s;
    logic [63:0] t;
    int a;
    s = x;
    case (o)
      0, 3:  begin a = (o == 0) ? im : r[4:0]; return sx32(x[31:0] << a); end
      1, 4:  begin a = (o == 1) ? im : r[4:0]; return sx32(x[31:0] >> a); end
      2, 5:  begin a = (o == 2) ? im : r[4:0]; t = s >>> a; return sx32(t[31:0]); end
      6, 9, 12:  begin a = (o == 6) ? im : (o == 9) ? r[5:0] : im + 32; return x << a; end
      7, 10, 13: begin a = (o == 7) ? im : (o == 10) ? r[5:0] : im + 32; return x >> a; end
      8, 11, 14: begin a = (o == 8) ? im : (o == 11) ? r[5:0] : im + 32; t = s >>> a; return t; end
      default: return 64'd0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [63:0] x, input logic [4:0] im,
                       input logic [63:0] r, input string tag);
    logic [63:0] exp;
    @(posedge clk); #2;
    op = o; opnd = x; imm = im; ramt = r;
    exp = model(o, x, im, r);
    @(negedge clk);
    checks++;
    if (res !== exp) begin
      fails++;
      $display("FAIL %s op=%0d: actual=%h expected=%h", tag, o, res, exp);
    end
  endtask

  task automatic t_reset_state;
    apply(4'd0, 64'd0, 5'd0, 64'd0, "R8");
  endtask

  task automatic t_word_left;
    apply(4'd0, 64'hFFFF_0000_0000_0001, 5'd31, 64'd0, "R1");
    apply(4'd0, 64'h0000_0000_1234_5678, 5'd4, 64'd0, "R1");
  endtask

  task automatic t_word_right;
    apply(4'd1, 64'hFFFF_FFFF_8000_0000, 5'd1, 64'd0, "R2");
    apply(4'd1, 64'hAAAA_5555_F000_000F, 5'd31, 64'd0, "R2");
  endtask

  task automatic t_word_arith;
    apply(4'd2, 64'h0000_0001_0000_0000, 5'd1, 64'd0, "R3");
    apply(4'd2, 64'hFFFF_FFFF_0000_0000, 5'd4, 64'd0, "R3");
    apply(4'd2, 64'h0000_0000_8000_0000, 5'd31, 64'd0, "R3");
  endtask

  task automatic t_reg_amounts;
    apply(4'd3, 64'h0000_0000_0000_00FF, 5'd0, 64'hFFFF_FFFF_FFFF_FFE4, "R4");
    apply(4'd4, 64'h0000_0000_FFFF_0000, 5'd0, 64'h0000_0000_0000_0128, "R4");
    apply(4'd5, 64'h8000_0000_0000_0000, 5'd0, 64'h0000_0000_0000_00A0, "R4");
    apply(4'd9, 64'h0000_0000_0000_0001, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    apply(4'd10, 64'h8000_0000_0000_0000, 5'd0, 64'h0000_0000_0000_01A0, "R4");
    apply(4'd11, 64'h8000_0000_0000_0000, 5'd0, 64'h0000_0000_0000_007F, "R4");
  endtask

  task automatic t_dword;
    apply(4'd6, 64'h0123_4567_89AB_CDEF, 5'd8, 64'd0, "R5");
    apply(4'd7, 64'hF000_0000_0000_0000, 5'd3, 64'd0, "R5");
    apply(4'd8, 64'hF000_0000_0000_0000, 5'd3, 64'd0, "R6");
    apply(4'd8, 64'h7000_0000_0000_0000, 5'd31, 64'd0, "R6");
  endtask

  task automatic t_plus32;
    apply(4'd12, 64'h0000_0000_DEAD_BEEF, 5'd0, 64'd0, "R7");
    apply(4'd13, 64'hDEAD_BEEF_0000_0000, 5'd31, 64'd0, "R7");
    apply(4'd14, 64'h8000_0000_0000_0000, 5'd31, 64'd0, "R7");
    apply(4'd14, 64'h4000_0000_1234_5678, 5'd0, 64'd0, "R7");
  endtask

  task automatic t_zero_amount;
    apply(4'd6, 64'hCAFE_F00D_1234_5678, 5'd0, 64'd0, "R8");
    apply(4'd1, 64'h1234_5678_8765_4321, 5'd0, 64'd0, "R8");
    apply(4'd11, 64'h8765_4321_0000_0001, 5'd0, 64'h40, "R8");
  endtask

  task automatic t_unused;
    apply(4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 5'd7, 64'h3F, "R9");
  endtask

  task automatic t_sweep;
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 32; a += 5) begin
        apply(o[3:0], 64'h9E37_79B9_7F4A_7C15, a[4:0], 64'hFFFF_FF00 | 64'(a * 2 + 1), "R4 sweep");
        apply(o[3:0], 64'h6A09_E667_F3BC_C908, a[4:0], 64'h0000_0000 | 64'(a + 32), "R7 sweep");
      end
  endtask

  initial begin
    opnd = '0; imm = '0; ramt = '0; op = '0;
    t_reset_state();
    t_word_left();
    t_word_right();
    t_word_arith();
    t_reg_amounts();
    t_dword();
    t_plus32();
    t_zero_amount();
    t_unused();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule